// File: doc/BRIEF.md
# Two-Level Radix Page Table Walker

This block translates a virtual address into a physical address by reading a two-level radix page table from memory. A requester presents a virtual address together with the current table root pointer. The walker then reads the directory entry and, when that entry points to a leaf table, the leaf entry. It returns either the physical address or a status code that says where the walk stopped.

The table is sparse. A directory entry can mark its whole leaf table as missing. A leaf entry can be valid but not resident in primary memory, and that case gets its own status. The walker keeps one walk in flight. It waits any number of cycles for the memory grant and for the returned word. In the cycle that shows a result it can already accept the next request, so a stream of walks needs no idle gap.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.
- R2: A request is taken only on a cycle with req_valid and req_ready both high. req_ready is high only when no walk is in flight or in the cycle that shows a result. A req_valid raised during a walk does not disturb that walk.
- R3: One cycle after a request is taken, mem_req_valid rises with address root_ptr + 4 × vaddr[31:22], using the values present when the request was taken. The address holds steady until mem_req_ready is seen.
- R4: The second read goes to address {directory entry bits 31:12, 12'b0} + 4 × vaddr[21:12].
- R5: In a table entry, bit 0 means valid, bit 1 means resident and bits 31:12 hold the physical page number. Bits 11:2 have no effect on the walk.
- R6: If the directory entry has bit 0 clear, the walk ends after one read with status 2'b01. For every fault status (01, 10 or 11), rsp_paddr is 0.
- R7: If the leaf entry has bit 0 clear, the status is 2'b10.
- R8: If the leaf entry is valid but bit 1 is clear, the status is 2'b11.
- R9: If the leaf entry is valid and resident, the status is 2'b00 and rsp_paddr = {leaf bits 31:12, vaddr[11:0]}.
- R10: The resident bit of a directory entry has no effect.
- R11: Grant delay and response delay may be any length. A mem_rsp_valid that arrives while no read is outstanding is ignored.
- R12: rsp_valid is high for exactly one cycle per walk. A request presented in that cycle is accepted, and its directory read follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 32 | Byte address of the current directory table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory grants the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result present (one cycle) |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_status | output | 2 | 00 ok, 01 directory absent, 10 leaf absent, 11 not resident |

## Verification
Two things can happen in the same cycle: a finished walk presents its result, and the next request is accepted. The bench provokes this by holding a second request on req_valid while the first walk is still stalled on a withheld memory grant. It then checks three things: the first result matches the first address, the second walk's directory read follows straight after, and the second result comes out of the scoreboard in order. Spurious memory responses are also sent while a read is still waiting for its grant, to show that only the response to an accepted read is used.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_REQ,
        W_DIR_WAIT,
        W_LEAF_REQ,
        W_LEAF_WAIT,
        W_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'b00,
        FLT_DIR_GONE  = 2'b01,
        FLT_LEAF_GONE = 2'b10,
        FLT_SWAPPED   = 2'b11
    } walk_status_e;

endpackage

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       word,
    output logic                    present,
    output logic                    in_ram,
    output logic [ADDR_W-OFF_W-1:0] frame
);
    logic unused_rsvd;

    assign present     = word[0];
    assign in_ram      = word[1];
    assign frame       = word[ADDR_W-1:OFF_W];
    assign unused_rsvd = ^word[OFF_W-1:2];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IW     = 10
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IW-1:0]     idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - IW - 2;

    assign addr = base + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] root_ptr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_status
);
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int LEAF_LO = OFF_W;
    localparam int DIR_LO  = OFF_W + IDX_W;
    localparam int DIR_W   = ADDR_W - DIR_LO;

    typedef struct packed {
        walk_state_e        st;
        logic [DIR_LO-1:0]  va;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  pa;
        walk_status_e       status;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic               ent_present;
    logic               ent_in_ram;
    logic [FRAME_W-1:0] ent_frame;
    logic [ADDR_W-1:0]  dir_addr;
    logic [ADDR_W-1:0]  leaf_addr;
    logic [ADDR_W-1:0]  leaf_base;
    logic               take_req;

    ptw_entry_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
        .word    (mem_rsp_data),
        .present (ent_present),
        .in_ram  (ent_in_ram),
        .frame   (ent_frame)
    );

    ptw_addr_gen #(.ADDR_W(ADDR_W), .IW(DIR_W)) u_dir_addr (
        .base (root_ptr),
        .idx  (req_vaddr[ADDR_W-1:DIR_LO]),
        .addr (dir_addr)
    );

    assign leaf_base = {ent_frame, {OFF_W{1'b0}}};

    ptw_addr_gen #(.ADDR_W(ADDR_W), .IW(IDX_W)) u_leaf_addr (
        .base (leaf_base),
        .idx  (r_q.va[DIR_LO-1:LEAF_LO]),
        .addr (leaf_addr)
    );

    assign req_ready     = (r_q.st == W_IDLE) || (r_q.st == W_DONE);
    assign take_req      = req_ready && req_valid;
    assign mem_req_valid = (r_q.st == W_DIR_REQ) || (r_q.st == W_LEAF_REQ);
    assign mem_req_addr  = r_q.addr;
    assign rsp_valid     = (r_q.st == W_DONE);
    assign rsp_paddr     = r_q.pa;
    assign rsp_status    = r_q.status;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            W_IDLE, W_DONE: begin
                if (take_req) begin
                    r_d.st   = W_DIR_REQ;
                    r_d.va   = req_vaddr[DIR_LO-1:0];
                    r_d.addr = dir_addr;
                end else begin
                    r_d.st = W_IDLE;
                end
            end
            W_DIR_REQ: begin
                if (mem_req_ready) r_d.st = W_DIR_WAIT;
            end
            W_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        r_d.st     = W_DONE;
                        r_d.status = FLT_DIR_GONE;
                        r_d.pa     = '0;
                    end else begin
                        r_d.st   = W_LEAF_REQ;
                        r_d.addr = leaf_addr;
                    end
                end
            end
            W_LEAF_REQ: begin
                if (mem_req_ready) r_d.st = W_LEAF_WAIT;
            end
            W_LEAF_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.st = W_DONE;
                    if (!ent_present) begin
                        r_d.status = FLT_LEAF_GONE;
                        r_d.pa     = '0;
                    end else if (!ent_in_ram) begin
                        r_d.status = FLT_SWAPPED;
                        r_d.pa     = '0;
                    end else begin
                        r_d.status = FLT_NONE;
                        r_d.pa     = {ent_frame, r_q.va[OFF_W-1:0]};
                    end
                end
            end
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= W_IDLE;
            r_q.va     <= '0;
            r_q.addr   <= '0;
            r_q.pa     <= '0;
            r_q.status <= FLT_NONE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] root_ptr,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [1:0]        rsp_status
);
    localparam int DIR_LO = OFF_W + IDX_W;
    localparam int DIR_W  = ADDR_W - DIR_LO;

    logic [ADDR_W-1:0] exp_dir;
    logic [OFF_W-1:0]  off_q;

    assign exp_dir = root_ptr + {{(ADDR_W-DIR_W-2){1'b0}}, req_vaddr[ADDR_W-1:DIR_LO], 2'b00};

    always_ff @(posedge clk) begin
        if (!rst_n)                      off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
    end

    p_busy_no_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_dir_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && mem_req_addr == $past(exp_dir)));

    p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'b00) |-> (rsp_paddr == '0));

    p_offset_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b00) |-> (rsp_paddr[OFF_W-1:0] == off_q));

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind pt_walker ptw_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .root_ptr      (root_ptr),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_status    (rsp_status)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_ptr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_status;

    always #5 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_status(rsp_status)
    );

    typedef struct {
        logic [1:0]  st;
        logic [31:0] pa;
        int          nr;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] mem_img [logic [31:0]];
    int          total = 0;
    int          bad = 0;
    int          nreads = 0;
    int          lat = 0;
    bit          stall_mode = 0;
    bit          stall_all = 0;
    bit          spurious = 0;
    bit          finished = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    function automatic exp_t model(input logic [31:0] va, input logic [31:0] root);
        exp_t e;
        logic [31:0] d, l;
        d = rd(root + {20'h0, va[31:22], 2'b00});
        if (!d[0]) begin
            e.st = 2'b01; e.pa = 32'h0; e.nr = 1;
        end else begin
            l = rd({d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00});
            e.nr = 2;
            if (!l[0])      begin e.st = 2'b10; e.pa = 32'h0; end
            else if (!l[1]) begin e.st = 2'b11; e.pa = 32'h0; end
            else            begin e.st = 2'b00; e.pa = {l[31:12], va[11:0]}; end
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: everything driven at the falling edge
    initial begin
        bit          pend = 0;
        int          cnt = 0;
        int          cyc = 0;
        logic [31:0] paddr_l = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(paddr_l);
                    pend = 0;
                end else cnt--;
            end else if (spurious && (cyc % 3 == 0)) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'hFFFF_FFFF;
            end
            mem_req_ready = stall_all ? 1'b0 : (stall_mode ? cyc[0] : 1'b1);
            if (mem_req_valid && mem_req_ready && rst_n) begin
                pend = 1; paddr_l = mem_req_addr; cnt = lat; nreads++;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R12", "result with empty scoreboard", rsp_paddr, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(rsp_status == e.st, "R6/R7/R8/R9", "status",
                        {30'h0, rsp_status}, {30'h0, e.st});
                    chk(rsp_paddr == e.pa, "R4/R5/R9/R10", "paddr", rsp_paddr, e.pa);
                    chk(nreads == e.nr, "R6", "entry reads", nreads, e.nr);
                end
                nreads = 0;
            end
        end
    end

    task automatic send(input logic [31:0] va, input logic [31:0] root);
        sb_q.push_back(model(va, root));
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; root_ptr = root;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle_drain();
        @(negedge clk);
        req_valid = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        mem_img[32'h0001_0004] = 32'h0002_0001;
        mem_img[32'h0002_000C] = 32'hABCD_E003;
        mem_img[32'h0002_0010] = 32'h1234_5002;
        mem_img[32'h0002_0014] = 32'h5555_5001;
        mem_img[32'h0001_000C] = 32'h0003_0FF3;
        mem_img[32'h0003_0008] = 32'h7777_7FF3;
        mem_img[32'h0001_0FFC] = 32'h0009_0001;
        mem_img[32'h0009_0FFC] = 32'hFEDC_B003;
        mem_img[32'h0005_0000] = 32'h0006_0003;
        mem_img[32'h0006_0004] = 32'h0004_2003;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'h0, req_ready}, 32'h1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", {31'h0, mem_req_valid}, 32'h0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);

        // basic outcomes, zero latency (R5 R6 R7 R8 R9 R10)
        send(32'h0040_3ABC, 32'h0001_0000); idle_drain();
        send(32'h0080_0000, 32'h0001_0000); idle_drain();
        send(32'h0040_4123, 32'h0001_0000); idle_drain();
        send(32'h0040_5FFF, 32'h0001_0000); idle_drain();
        send(32'h00C0_2010, 32'h0001_0000); idle_drain();
        send(32'hFFFF_FFFF, 32'h0001_0000); idle_drain();
        send(32'h0000_1234, 32'h0005_0000); idle_drain();
        send(32'h0040_3ABC, 32'h0005_0000); idle_drain();

        // R11: slow grant, slow data, stray responses
        lat = 4; stall_mode = 1; spurious = 1;
        send(32'h0040_3ABC, 32'h0001_0000);
        send(32'h0040_5FFF, 32'h0001_0000);
        send(32'h0080_0000, 32'h0001_0000);
        send(32'hFFFF_FFFF, 32'h0001_0000);
        idle_drain();
        lat = 0; stall_mode = 0; spurious = 0;

        // R2 R3 R12: held grant, competing request, overlap with result
        stall_all = 1;
        sb_q.push_back(model(32'h00C0_2010, 32'h0001_0000));
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h00C0_2010; root_ptr = 32'h0001_0000;
        @(posedge clk);
        @(negedge clk);
        sb_q.push_back(model(32'h0040_3ABC, 32'h0001_0000));
        req_vaddr = 32'h0040_3ABC;
        chk(req_ready == 1'b0, "R2", "ready during walk", {31'h0, req_ready}, 32'h0);
        chk(mem_req_valid == 1'b1, "R3", "read issued", {31'h0, mem_req_valid}, 32'h1);
        chk(mem_req_addr == 32'h0001_000C, "R3", "directory address", mem_req_addr, 32'h0001_000C);
        held = mem_req_addr;
        repeat (3) @(negedge clk);
        chk(mem_req_valid == 1'b1 && mem_req_addr == held, "R3", "address held under stall",
            mem_req_addr, held);
        stall_all = 0;
        while (!rsp_valid) @(negedge clk);
        chk(req_ready == 1'b1, "R12", "ready in result cycle", {31'h0, req_ready}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req_valid == 1'b1 && mem_req_addr == 32'h0001_0004, "R12",
            "next read right after result", mem_req_addr, 32'h0001_0004);
        idle_drain();

        chk(sb_q.size() == 0, "R12", "results outstanding", sb_q.size(), 32'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule